// File: doc/BRIEF.md
# Accumulator CPU Fetch-Execute Core

This block is a small accumulator processor built around a phase-sequenced control unit. Each instruction is one 24-bit word held in an internal synchronous RAM. The upper byte is the opcode and the lower sixteen bits are the operand. A word is read in a single access. Four fixed fetch phases then move the address, the instruction register and the program counter. After that, one execute phase runs, and instructions that read memory add one write-back phase.

The datapath holds these parts:
- a 16-bit accumulator;
- a 16-bit output register;
- an address selector that chooses between the program counter and the operand;
- an immediate selector that chooses between the arithmetic result and the operand.

The core can load and store memory words, add and subtract memory words, load an immediate value, sample the input port, drive the output register and jump. The test environment places a program in the RAM before reset is released. It observes the results through the accumulator, the output register and the latched opcode.

Top module: `cpu24_core`

## Requirements
- R1: The instruction register splits the fetched word so that bits [23:16] form the opcode and bits [15:0] form the operand. The opcode is visible on `opcode_q` two clock edges after a fetch starts.
- R2: Reset (active-low `rst_n`) has priority over everything else. It clears the program counter, the accumulator, the output register and the opcode to zero. Execution then restarts at address 0.
- R3: Every instruction passes through fetch phases F0 (PC drives the RAM address), F1 (the word is loaded into the instruction register), F2 (PC increments) and F3 (decode), then one execute phase. Instructions that do not read memory take 5 cycles.
- R4: Opcode 10h loads the accumulator with the low 16 bits of the RAM word at the operand address. It takes 6 cycles.
- R5: Opcode 11h writes the accumulator, zero-extended, into the RAM word at the operand address. A later 10h from that address returns the stored value.
- R6: Opcode 12h adds the RAM word at the operand address to the accumulator. Opcode 13h subtracts it. Both results wrap modulo 2^16, and both take 6 cycles.
- R7: Opcode 20h loads the operand itself into the accumulator through the immediate selector.
- R8: Opcode 30h copies `in_port` into the accumulator. Opcode 31h copies the accumulator into `out_port`.
- R9: Opcode 40h loads the program counter with the operand. This load takes priority over the increment, so the next fetch comes from the operand address.
- R10: Any other opcode is a no-op. The accumulator and the output register keep their values, and execution continues at the next address.
- R11: The program counter is AW bits wide and wraps from the last address to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_port | input | 16 | Value sampled by opcode 30h |
| out_port | output | 16 | Output register written by opcode 31h |
| acc_q | output | 16 | Accumulator contents |
| opcode_q | output | 8 | Opcode currently held in the instruction register |

## Verification
The opcode of a new instruction appears two edges after its F0 phase. Results of the 5-cycle instructions are visible after the fifth edge. Results of the 6-cycle memory-read instructions (10h, 12h, 13h) are visible after the sixth edge. The bench walks the program one instruction at a time and counts exactly that many rising edges per step. It samples on the falling edge, checking that the opcode is still the previous one after the first edge and the new one after the second. Expected accumulator and output values come from wrap-around sums done in the bench.

// File: rtl/cpu24_pkg.sv
package cpu24_pkg;

  typedef enum logic [2:0] {
    PH_F0, PH_F1, PH_F2, PH_F3, PH_EX, PH_WB
  } phase_e;

  typedef enum logic [1:0] {
    ALU_PASS_B, ALU_ADD, ALU_SUB, ALU_PASS_A
  } alu_mode_e;

  localparam logic [7:0] OP_LDA = 8'h10;
  localparam logic [7:0] OP_STA = 8'h11;
  localparam logic [7:0] OP_ADD = 8'h12;
  localparam logic [7:0] OP_SUB = 8'h13;
  localparam logic [7:0] OP_LDI = 8'h20;
  localparam logic [7:0] OP_IN  = 8'h30;
  localparam logic [7:0] OP_OUT = 8'h31;
  localparam logic [7:0] OP_JMP = 8'h40;

  function automatic logic [15:0] alu_eval(alu_mode_e m, logic [15:0] a, logic [15:0] b);
    case (m)
      ALU_ADD:    return a + b;
      ALU_SUB:    return a - b;
      ALU_PASS_A: return a;
      default:    return b;
    endcase
  endfunction

  function automatic logic op_reads_mem(logic [7:0] op);
    return (op == OP_LDA) || (op == OP_ADD) || (op == OP_SUB);
  endfunction

  function automatic logic op_known(logic [7:0] op);
    return op_reads_mem(op) || (op == OP_STA) || (op == OP_LDI) ||
           (op == OP_IN) || (op == OP_OUT) || (op == OP_JMP);
  endfunction

endpackage

// File: rtl/cpu24_pc.sv
module cpu24_pc #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic          inc,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (ld)  q <= d;
    else if (inc) q <= q + 1'b1;
  end
endmodule

// File: rtl/cpu24_ram.sv
module cpu24_ram #(
  parameter int AW = 8,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/cpu24_ctrl.sv
module cpu24_ctrl
  import cpu24_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] opcode,
  output phase_e     phase,
  output logic       addr_sel,
  output logic       ram_we,
  output logic       ir_ld,
  output logic       pc_inc,
  output logic       pc_ld,
  output logic       acc_ld,
  output logic       out_ld,
  output logic       im_sel,
  output logic       in_sel,
  output alu_mode_e  alu_mode
);
  phase_e phase_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_F0;
    else        phase <= phase_nx;
  end

  always_comb begin
    case (phase)
      PH_F0:   phase_nx = PH_F1;
      PH_F1:   phase_nx = PH_F2;
      PH_F2:   phase_nx = PH_F3;
      PH_F3:   phase_nx = PH_EX;
      PH_EX:   phase_nx = op_reads_mem(opcode) ? PH_WB : PH_F0;
      default: phase_nx = PH_F0;
    endcase
  end

  always_comb begin
    addr_sel = (phase != PH_EX) && (phase != PH_WB);
    ir_ld    = (phase == PH_F1);
    pc_inc   = (phase == PH_F2);
    pc_ld    = (phase == PH_EX) && (opcode == OP_JMP);
    ram_we   = (phase == PH_EX) && (opcode == OP_STA);
    out_ld   = (phase == PH_EX) && (opcode == OP_OUT);
    im_sel   = (opcode == OP_LDI);
    in_sel   = (opcode == OP_IN);
    acc_ld   = ((phase == PH_EX) && ((opcode == OP_LDI) || (opcode == OP_IN))) ||
               ((phase == PH_WB) && op_reads_mem(opcode));
    case (opcode)
      OP_ADD:  alu_mode = ALU_ADD;
      OP_SUB:  alu_mode = ALU_SUB;
      default: alu_mode = ALU_PASS_B;
    endcase
  end
endmodule

// File: rtl/cpu24_core.sv
module cpu24_core
  import cpu24_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] in_port,
  output logic [15:0] out_port,
  output logic [15:0] acc_q,
  output logic [7:0]  opcode_q
);
  localparam int IW = 24;
  localparam int DW = 16;

  phase_e        phase;
  alu_mode_e     alu_mode;
  logic          addr_sel, ram_we, ir_ld, pc_inc, pc_ld, acc_ld, out_ld, im_sel, in_sel;
  logic [AW-1:0] pc, ram_addr;
  logic [IW-1:0] rdata, ir;
  logic [DW-1:0] operand, alu_b, alu_f, acc_d;

  assign opcode_q = ir[IW-1:DW];
  assign operand  = ir[DW-1:0];

  cpu24_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .opcode(opcode_q), .phase(phase),
    .addr_sel(addr_sel), .ram_we(ram_we), .ir_ld(ir_ld), .pc_inc(pc_inc),
    .pc_ld(pc_ld), .acc_ld(acc_ld), .out_ld(out_ld), .im_sel(im_sel),
    .in_sel(in_sel), .alu_mode(alu_mode)
  );

  cpu24_pc #(.AW(AW)) u_pc (
    .clk(clk), .rst_n(rst_n), .ld(pc_ld), .inc(pc_inc),
    .d(operand[AW-1:0]), .q(pc)
  );

  assign ram_addr = addr_sel ? pc : operand[AW-1:0];

  cpu24_ram #(.AW(AW), .DW(IW)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr),
    .wdata({{(IW-DW){1'b0}}, acc_q}), .rdata(rdata)
  );

  assign alu_b = in_sel ? in_port : rdata[DW-1:0];
  assign alu_f = alu_eval(alu_mode, acc_q, alu_b);
  assign acc_d = im_sel ? operand : alu_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir       <= '0;
      acc_q    <= '0;
      out_port <= '0;
    end else begin
      if (ir_ld)  ir       <= rdata;
      if (acc_ld) acc_q    <= acc_d;
      if (out_ld) out_port <= acc_q;
    end
  end
endmodule

// File: rtl/cpu24_chk.sv
module cpu24_chk
  import cpu24_pkg::*;
#(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input phase_e        phase,
  input logic [7:0]    opc,
  input logic [15:0]   opr,
  input logic [AW-1:0] pc,
  input logic [23:0]   rdata,
  input logic          ram_we,
  input logic [15:0]   acc,
  input logic [15:0]   outp
);
  p_split_r1: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_F1 |=> opc == $past(rdata[23:16]) && opr == $past(rdata[15:0]));

  p_f0_r3: assert property (@(posedge clk) disable iff (!rst_n) phase == PH_F0 |=> phase == PH_F1);
  p_f1_r3: assert property (@(posedge clk) disable iff (!rst_n) phase == PH_F1 |=> phase == PH_F2);
  p_f2_r3: assert property (@(posedge clk) disable iff (!rst_n) phase == PH_F2 |=> phase == PH_F3);
  p_f3_r3: assert property (@(posedge clk) disable iff (!rst_n) phase == PH_F3 |=> phase == PH_EX);

  p_lda_r4: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_WB && opc == OP_LDA |=> acc == $past(rdata[15:0]));

  p_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> phase == PH_EX && opc == OP_STA);

  p_jump_r9: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_EX && opc == OP_JMP |=> pc == $past(opr[AW-1:0]));

  p_nop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_EX && !op_known(opc) |=> $stable(acc) && $stable(outp) && phase == PH_F0);

  p_pc_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_F2 |=> pc == $past(pc) + AW'(1));
endmodule

bind cpu24_core cpu24_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .opc(opcode_q), .opr(operand),
  .pc(pc), .rdata(rdata), .ram_we(ram_we), .acc(acc_q), .outp(out_port)
);

// File: tb/test_cpu24_core.sv
module test_cpu24_core;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] in_port = '0;
  logic [15:0] out_port, acc_q;
  logic [7:0]  opcode_q;
  int          n_chk = 0;
  int          n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu24_core #(.AW(AW)) i_cpu24_core (
    .clk(clk), .rst_n(rst_n), .in_port(in_port),
    .out_port(out_port), .acc_q(acc_q), .opcode_q(opcode_q)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic edge1();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one instruction: n edges; opcode changes after exactly two edges (R1, R3)
  task automatic step(int n, logic [7:0] exp_op, logic [7:0] prev_op);
    edge1();
    chk("R3 opcode held in F1", {8'h00, opcode_q}, {8'h00, prev_op});
    edge1();
    chk("R1 opcode after F1", {8'h00, opcode_q}, {8'h00, exp_op});
    for (int i = 2; i < n; i++) edge1();
  endtask

  function automatic logic [23:0] word(logic [7:0] op, logic [15:0] v);
    return {op, v};
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [15:0] exp_acc;
    for (int k = 0; k < 2 ** AW; k++) i_cpu24_core.u_ram.mem[k] = '0;
    i_cpu24_core.u_ram.mem[0]    = word(8'h20, 16'h1234);
    i_cpu24_core.u_ram.mem[1]    = word(8'h11, 16'h0080);
    i_cpu24_core.u_ram.mem[2]    = word(8'h20, 16'h0000);
    i_cpu24_core.u_ram.mem[3]    = word(8'h10, 16'h0080);
    i_cpu24_core.u_ram.mem[4]    = word(8'h12, 16'h0081);
    i_cpu24_core.u_ram.mem[5]    = word(8'h13, 16'h0082);
    i_cpu24_core.u_ram.mem[6]    = word(8'h31, 16'h0000);
    i_cpu24_core.u_ram.mem[7]    = word(8'h30, 16'h0000);
    i_cpu24_core.u_ram.mem[8]    = word(8'h77, 16'h9999);
    i_cpu24_core.u_ram.mem[9]    = word(8'h31, 16'h0000);
    i_cpu24_core.u_ram.mem[10]   = word(8'h40, 16'h00FE);
    i_cpu24_core.u_ram.mem[8'h81] = 24'h00F000;
    i_cpu24_core.u_ram.mem[8'h82] = 24'h000235;
    i_cpu24_core.u_ram.mem[8'hFE] = word(8'h20, 16'h0042);
    i_cpu24_core.u_ram.mem[8'hFF] = word(8'h20, 16'h0077);

    repeat (3) @(negedge clk);
    chk("R2 reset opcode", {8'h00, opcode_q}, 16'h0000);
    chk("R2 reset acc", acc_q, 16'h0000);
    chk("R2 reset out", out_port, 16'h0000);
    rst_n = 1'b1;

    step(5, 8'h20, 8'h00); chk("R7 immediate load", acc_q, 16'h1234);
    step(5, 8'h11, 8'h20); chk("R5 store keeps acc", acc_q, 16'h1234);
    step(5, 8'h20, 8'h11); chk("R7 immediate zero", acc_q, 16'h0000);
    step(6, 8'h10, 8'h20); chk("R4 R5 load stored word", acc_q, 16'h1234);
    exp_acc = 16'h1234 + 16'hF000;
    step(6, 8'h12, 8'h10); chk("R6 add wraps", acc_q, exp_acc);
    exp_acc = exp_acc - 16'h0235;
    step(6, 8'h13, 8'h12); chk("R6 subtract wraps", acc_q, exp_acc);
    step(5, 8'h31, 8'h13); chk("R8 output write", out_port, exp_acc);
    in_port = 16'hA5C3;
    step(5, 8'h30, 8'h31); chk("R8 input read", acc_q, 16'hA5C3);
    in_port = 16'h0F0F;
    step(5, 8'h77, 8'h30);
    chk("R10 nop keeps acc", acc_q, 16'hA5C3);
    chk("R10 nop keeps out", out_port, exp_acc);
    step(5, 8'h31, 8'h77); chk("R10 next address after nop", out_port, 16'hA5C3);
    step(5, 8'h40, 8'h31); chk("R9 jump leaves acc", acc_q, 16'hA5C3);
    step(5, 8'h20, 8'h40); chk("R9 fetch from jump target", acc_q, 16'h0042);
    step(5, 8'h20, 8'h20); chk("R11 last address", acc_q, 16'h0077);
    step(5, 8'h20, 8'h20); chk("R11 wrap to address 0", acc_q, 16'h1234);

    // reset mid-instruction restarts at address 0 (R2)
    edge1(); edge1(); edge1();
    rst_n = 1'b0;
    @(negedge clk);
    chk("R2 mid-run reset acc", acc_q, 16'h0000);
    chk("R2 mid-run reset opcode", {8'h00, opcode_q}, 16'h0000);
    rst_n = 1'b1;
    step(5, 8'h20, 8'h00); chk("R2 restart at 0", acc_q, 16'h1234);

    // sweep of input values through IN then OUT (R8)
    for (int v = 0; v < 16; v++) begin
      i_cpu24_core.u_ram.mem[0] = word(8'h30, 16'h0000);
      i_cpu24_core.u_ram.mem[1] = word(8'h31, 16'h0000);
      i_cpu24_core.u_ram.mem[2] = word(8'h40, 16'h0000);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      in_port = 16'(v * 16'h1111 + 16'h0101);
      step(5, 8'h30, 8'h00);
      step(5, 8'h31, 8'h30);
      chk("R8 sweep out", out_port, 16'(v * 16'h1111 + 16'h0101));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule